// File: doc/BRIEF.md
# YUV to RGB Pixel Converter

This block turns a stream of 8-bit luma/chroma pixels into 8-bit red, green and blue pixels using fixed small integer weights and a divide-by-64 shift. Each chroma sample is first recentred around zero. Each colour channel then takes a weighted chroma term, scaled down by an arithmetic right shift of six bits, and adds it to or subtracts it from luma. The result is limited to the pixel range.

Pixels enter and leave on valid/ready handshakes. The datapath has three register stages: chroma offset and multiply, then shift and combine, then saturate. One pixel is accepted per clock while the output side keeps up. When the consumer holds ready low, the whole pipeline freezes in place.

Top module: `yuv_rgb_conv`

## Requirements
- R1: Chroma inputs are recentred before use: Cb' = in_u - 128 and Cr' = in_v - 128, both signed, so in_u = in_v = 128 yields out_r = out_g = out_b = in_y.
- R2: out_r = clamp(in_y + floor(90 * Cr' / 64)).
- R3: out_g = clamp(in_y - floor((22 * Cb' + 46 * Cr') / 64)), where the two products are added before the shift (Cb' = Cr' = 1 gives in_y - 1, not in_y).
- R4: out_b = clamp(in_y + floor(114 * Cb' / 64)).
- R5: The divide by 64 is an arithmetic shift that rounds toward minus infinity, so Cr' = -1 lowers red by 2.
- R6: Every channel is saturated to 0..255: a negative result gives 0 and a result above 255 gives 255.
- R7: A pixel accepted on clock edge n is presented with out_valid high after edge n+2 when out_ready stays high. With out_ready high, in_ready stays high, so one pixel is taken every cycle.
- R8: While out_valid is high and out_ready is low, the output pixel holds steady, in_ready is low, and no more than three pixels are in flight. Every accepted pixel leaves exactly once and in order.
- R9: Synchronous active-high rst empties the pipeline: in the cycle after rst is sampled, out_valid is low and in_ready is high. Pixels held before reset are never delivered.
- R10: Input data presented while in_valid is low is ignored and produces no output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel this cycle |
| in_y | input | 8 | Luma, unsigned |
| in_u | input | 8 | Blue-difference chroma, unsigned with offset 128 |
| in_v | input | 8 | Red-difference chroma, unsigned with offset 128 |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_r | output | 8 | Red, saturated |
| out_g | output | 8 | Green, saturated |
| out_b | output | 8 | Blue, saturated |

## Verification
The handshake assertions assume that rst is held for at least three cycles before the first pixel, and that in_valid is low during reset, so the latency property never looks back at a transfer from before reset. The bench drives in_valid low throughout every reset. It changes inputs only just after a rising edge, so each handshake is evaluated on settled values. Out_ready is toggled freely, including while the pipeline is full, because the stall-hold properties rely only on the block itself.

// File: rtl/yuv_rgb_pkg.sv
`timescale 1ns/1ps
package yuv_rgb_pkg;

   // number of weighted chroma products formed in the first stage
   localparam int NUM_PROD = 4;
   // number of colour channels leaving the block
   localparam int NUM_CHAN = 3;
   // fixed pipeline depth of the datapath
   localparam int PIPE_DEPTH = 3;

   typedef enum logic [1:0] {
      CH_RED   = 2'd0,
      CH_GREEN = 2'd1,
      CH_BLUE  = 2'd2
   } chan_e;

   // width of a recentred chroma sample (one sign bit added)
   function automatic int ofs_width(input int pix_w);
      return pix_w + 1;
   endfunction

   // width that holds any chroma product without overflow
   function automatic int prod_width(input int pix_w, input int coef_w);
      return ofs_width(pix_w) + coef_w;
   endfunction

   // width of a stage-two result (sum of two products plus luma)
   function automatic int res_width(input int pix_w, input int coef_w);
      return prod_width(pix_w, coef_w) + 2;
   endfunction

endpackage

// File: rtl/yuv_rgb_flow.sv
`timescale 1ns/1ps
module yuv_rgb_flow #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic out_ready,
   output logic in_ready,
   output logic adv,
   output logic out_valid
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("yuv_rgb_flow: STAGES must be at least 1");
      end
   endgenerate

   logic vld [STAGES];

   // the whole pipe moves when the last slot is empty or being drained
   assign adv       = ~vld[STAGES-1] | out_ready;
   assign in_ready  = adv;
   assign out_valid = vld[STAGES-1];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_slot
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)      vld[s] <= 1'b0;
               else if (adv) vld[s] <= in_valid;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst)      vld[s] <= 1'b0;
               else if (adv) vld[s] <= vld[s-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/yuv_rgb_mul.sv
`timescale 1ns/1ps
module yuv_rgb_mul
   import yuv_rgb_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int K_RV   = 90,
   parameter int K_GU   = 22,
   parameter int K_GV   = 46,
   parameter int K_BU   = 114,
   localparam int OFS_W  = ofs_width(PIX_W),
   localparam int PROD_W = prod_width(PIX_W, COEF_W)
) (
   input  logic                              clk,
   input  logic                              adv,
   input  logic [PIX_W-1:0]                  in_y,
   input  logic [PIX_W-1:0]                  in_u,
   input  logic [PIX_W-1:0]                  in_v,
   output logic [PIX_W-1:0]                  y_q,
   output logic [NUM_PROD-1:0][PROD_W-1:0]   prod_q
);

   localparam int KMAX = (1 << (COEF_W - 1)) - 1;
   localparam int KTAB [NUM_PROD] = '{K_RV, K_GU, K_GV, K_BU};
   // 1: product uses red-difference chroma, 0: blue-difference chroma
   localparam bit USE_V [NUM_PROD] = '{1'b1, 1'b0, 1'b1, 1'b0};
   localparam logic signed [OFS_W-1:0] BIAS = OFS_W'(1 << (PIX_W - 1));

   generate
      for (genvar k = 0; k < NUM_PROD; k++) begin : g_kchk
         if (KTAB[k] < 0 || KTAB[k] > KMAX) begin : g_bad_coef
            $error("yuv_rgb_mul: coefficient does not fit COEF_W");
         end
      end
   endgenerate

   logic signed [OFS_W-1:0]  u_ofs, v_ofs;
   logic signed [PROD_W-1:0] u_ext, v_ext;
   logic signed [PROD_W-1:0] prod_d [NUM_PROD];

   assign u_ofs = $signed({1'b0, in_u}) - BIAS;
   assign v_ofs = $signed({1'b0, in_v}) - BIAS;
   assign u_ext = PROD_W'(u_ofs);
   assign v_ext = PROD_W'(v_ofs);

   generate
      for (genvar k = 0; k < NUM_PROD; k++) begin : g_prod
         localparam logic signed [PROD_W-1:0] KW = PROD_W'(KTAB[k]);
         if (USE_V[k]) begin : g_v
            assign prod_d[k] = v_ext * KW;
         end else begin : g_u
            assign prod_d[k] = u_ext * KW;
         end
         always_ff @(posedge clk) begin
            if (adv) prod_q[k] <= prod_d[k];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (adv) y_q <= in_y;
   end

endmodule

// File: rtl/yuv_rgb_mix.sv
`timescale 1ns/1ps
module yuv_rgb_mix
   import yuv_rgb_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int PROD_W = 17,
   parameter int RES_W  = 19,
   parameter int SHIFT  = 6
) (
   input  logic                              clk,
   input  logic                              adv,
   input  logic [PIX_W-1:0]                  y_d,
   input  logic [NUM_PROD-1:0][PROD_W-1:0]   prod_d,
   output logic [NUM_CHAN-1:0][RES_W-1:0]    res_q
);

   localparam int SUM_W = PROD_W + 1;

   generate
      if (SHIFT < 0 || SHIFT >= PROD_W) begin : g_bad_shift
         $error("yuv_rgb_mix: SHIFT out of range");
      end
      if (RES_W < SUM_W + 1) begin : g_bad_res
         $error("yuv_rgb_mix: RES_W too narrow");
      end
   endgenerate

   // channel order: red adds, green subtracts, blue adds
   localparam bit SUBTRACT [NUM_CHAN] = '{1'b0, 1'b1, 1'b0};

   logic signed [SUM_W-1:0] term [NUM_CHAN];
   logic signed [SUM_W-1:0] shd  [NUM_CHAN];
   logic signed [RES_W-1:0] y_s;
   logic signed [RES_W-1:0] res_d [NUM_CHAN];

   // green combines both chroma products before any shift
   assign term[CH_RED]   = SUM_W'($signed(prod_d[0]));
   assign term[CH_GREEN] = SUM_W'($signed(prod_d[1])) + SUM_W'($signed(prod_d[2]));
   assign term[CH_BLUE]  = SUM_W'($signed(prod_d[3]));

   assign y_s = $signed({{(RES_W - PIX_W){1'b0}}, y_d});

   generate
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
         assign shd[c] = term[c] >>> SHIFT;
         if (SUBTRACT[c]) begin : g_sub
            assign res_d[c] = y_s - RES_W'(shd[c]);
         end else begin : g_add
            assign res_d[c] = y_s + RES_W'(shd[c]);
         end
         always_ff @(posedge clk) begin
            if (adv) res_q[c] <= res_d[c];
         end
      end
   endgenerate

endmodule

// File: rtl/yuv_rgb_sat.sv
`timescale 1ns/1ps
module yuv_rgb_sat
   import yuv_rgb_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int RES_W = 19
) (
   input  logic                              clk,
   input  logic                              adv,
   input  logic [NUM_CHAN-1:0][RES_W-1:0]    res_d,
   output logic [NUM_CHAN-1:0][PIX_W-1:0]    pix_q
);

   generate
      if (RES_W < PIX_W + 2) begin : g_bad_width
         $error("yuv_rgb_sat: RES_W must exceed PIX_W by two");
      end
   endgenerate

   logic [PIX_W-1:0] pix_d [NUM_CHAN];

   generate
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
         always_comb begin
            if (res_d[c][RES_W-1])
               pix_d[c] = '0;
            else if (|res_d[c][RES_W-2:PIX_W])
               pix_d[c] = '1;
            else
               pix_d[c] = res_d[c][PIX_W-1:0];
         end
         always_ff @(posedge clk) begin
            if (adv) pix_q[c] <= pix_d[c];
         end
      end
   endgenerate

endmodule

// File: rtl/yuv_rgb_conv.sv
`timescale 1ns/1ps
module yuv_rgb_conv
   import yuv_rgb_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int SHIFT  = 6,
   parameter int K_RV   = 90,
   parameter int K_GU   = 22,
   parameter int K_GV   = 46,
   parameter int K_BU   = 114
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_y,
   input  logic [PIX_W-1:0] in_u,
   input  logic [PIX_W-1:0] in_v,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PIX_W-1:0] out_r,
   output logic [PIX_W-1:0] out_g,
   output logic [PIX_W-1:0] out_b
);

   localparam int PROD_W = prod_width(PIX_W, COEF_W);
   localparam int RES_W  = res_width(PIX_W, COEF_W);

   generate
      if (PIX_W < 2) begin : g_bad_pix
         $error("yuv_rgb_conv: PIX_W must be at least 2");
      end
      if (COEF_W < 2) begin : g_bad_coef
         $error("yuv_rgb_conv: COEF_W must be at least 2");
      end
   endgenerate

   logic                              adv;
   logic [PIX_W-1:0]                  s1_y;
   logic [NUM_PROD-1:0][PROD_W-1:0]   s1_prod;
   logic [NUM_CHAN-1:0][RES_W-1:0]    s2_res;
   logic [NUM_CHAN-1:0][PIX_W-1:0]    s3_pix;

   yuv_rgb_flow #(
      .STAGES   (PIPE_DEPTH)
   ) u_flow (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .out_ready(out_ready),
      .in_ready (in_ready),
      .adv      (adv),
      .out_valid(out_valid)
   );

   yuv_rgb_mul #(
      .PIX_W (PIX_W),
      .COEF_W(COEF_W),
      .K_RV  (K_RV),
      .K_GU  (K_GU),
      .K_GV  (K_GV),
      .K_BU  (K_BU)
   ) u_mul (
      .clk   (clk),
      .adv   (adv),
      .in_y  (in_y),
      .in_u  (in_u),
      .in_v  (in_v),
      .y_q   (s1_y),
      .prod_q(s1_prod)
   );

   yuv_rgb_mix #(
      .PIX_W (PIX_W),
      .PROD_W(PROD_W),
      .RES_W (RES_W),
      .SHIFT (SHIFT)
   ) u_mix (
      .clk   (clk),
      .adv   (adv),
      .y_d   (s1_y),
      .prod_d(s1_prod),
      .res_q (s2_res)
   );

   yuv_rgb_sat #(
      .PIX_W(PIX_W),
      .RES_W(RES_W)
   ) u_sat (
      .clk  (clk),
      .adv  (adv),
      .res_d(s2_res),
      .pix_q(s3_pix)
   );

   assign out_r = s3_pix[CH_RED];
   assign out_g = s3_pix[CH_GREEN];
   assign out_b = s3_pix[CH_BLUE];

endmodule

// File: rtl/yuv_rgb_conv_chk.sv
`timescale 1ns/1ps
module yuv_rgb_conv_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [PIX_W-1:0] out_r,
   input logic [PIX_W-1:0] out_g,
   input logic [PIX_W-1:0] out_b
);

   logic       fire_in, fire_out;
   logic [2:0] occ;

   assign fire_in  = in_valid & in_ready;
   assign fire_out = out_valid & out_ready;

   // pixels taken but not yet delivered
   always_ff @(posedge clk) begin
      if (rst) occ <= 3'd0;
      else     occ <= occ + 3'(fire_in) - 3'(fire_out);
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b))); // R8
   AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      occ <= 3'd3); // R8
   AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready); // R7
   AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      ($past(fire_in, 3) && $past(in_ready, 2) && $past(in_ready, 1)) |-> out_valid); // R7
   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (occ != 3'd0)); // R10
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && in_ready)); // R9

endmodule

bind yuv_rgb_conv yuv_rgb_conv_chk #(
   .PIX_W(PIX_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_r    (out_r),
   .out_g    (out_g),
   .out_b    (out_b)
);

// File: tb/test_yuv_rgb_conv.sv
`timescale 1ns/1ps
module test_yuv_rgb_conv;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_y = 8'd0, in_u = 8'd0, in_v = 8'd0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_r, out_g, out_b;

   always #2.5 clk = ~clk;

   yuv_rgb_conv i_yuv_rgb_conv (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_y     (in_y),
      .in_u     (in_u),
      .in_v     (in_v),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_r    (out_r),
      .out_g    (out_g),
      .out_b    (out_b)
   );

   // hand-worked vectors: {y, u, v, r, g, b}
   localparam logic [47:0] VEC [8] = '{
      {8'd100, 8'd128, 8'd128, 8'd100, 8'd100, 8'd100}, // R1 neutral chroma
      {8'd100, 8'd129, 8'd129, 8'd101, 8'd99,  8'd101}, // R3 sum before shift
      {8'd100, 8'd128, 8'd127, 8'd98,  8'd101, 8'd100}, // R5 floor on negatives
      {8'd255, 8'd128, 8'd255, 8'd255, 8'd164, 8'd255}, // R6 high clamp
      {8'd0,   8'd0,   8'd0,   8'd0,   8'd136, 8'd0  }, // R6 low clamp
      {8'd0,   8'd255, 8'd128, 8'd0,   8'd0,   8'd226}, // R4 blue range
      {8'd50,  8'd200, 8'd60,  8'd0,   8'd75,  8'd178}, // R2 red low clamp
      {8'd128, 8'd100, 8'd180, 8'd201, 8'd101, 8'd78 }  // R2 R3 R4 mixed
   };

   function automatic int fdiv64(input int x);
      if (x >= 0) return x / 64;
      return -((-x + 63) / 64);
   endfunction

   function automatic logic [7:0] clip(input int x);
      if (x < 0)   return 8'd0;
      if (x > 255) return 8'd255;
      return 8'(x);
   endfunction

   function automatic logic [23:0] ref_pix(input logic [7:0] y, u, v);
      int cb, cr;
      cb = int'(u) - 128;
      cr = int'(v) - 128;
      return {clip(int'(y) + fdiv64(90 * cr)),
              clip(int'(y) - fdiv64(22 * cb + 46 * cr)),
              clip(int'(y) + fdiv64(114 * cb))};
   endfunction

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // scoreboard, owned by the monitor
   logic [23:0] cur_exp = 24'd0;
   logic [23:0] sb [256];
   logic [7:0]  wr_p = 8'd0, rd_p = 8'd0;
   int          mon_checks = 0, mon_fails = 0;
   int          n_checks = 0, n_fails = 0;
   int          cycles = 0;

   always @(negedge clk) begin
      if (rst) begin
         rd_p <= wr_p;
      end else begin
         if (in_valid && in_ready) begin
            sb[wr_p] <= cur_exp;
            wr_p     <= wr_p + 8'd1;
         end
         if (out_valid && out_ready) begin
            mon_checks <= mon_checks + 1;
            if (rd_p == wr_p) begin
               mon_fails <= mon_fails + 1;
               $display("FAIL R10: output %h with nothing pending (expected none)",
                        {out_r, out_g, out_b});
            end else begin
               if ({out_r, out_g, out_b} !== sb[rd_p]) begin
                  mon_fails <= mon_fails + 1;
                  $display("FAIL R2 R3 R4 R6: pixel rgb actual %h expected %h",
                           {out_r, out_g, out_b}, sb[rd_p]);
               end
               rd_p <= rd_p + 8'd1;
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed",
                  n_checks + mon_checks + 1, n_fails + mon_fails + 1);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] y, u, v, input logic [23:0] exp);
      in_valid = 1'b1;
      in_y = y; in_u = u; in_v = v;
      cur_exp = exp;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      out_ready = 1'b1;
      repeat (8) @(posedge clk);
      #1;
   endtask

   logic [23:0] held;
   logic [31:0] seed_a = 32'h1badf00d;
   logic [31:0] seed_b = 32'h5eed1234;
   int          n;
   realtime     t0;

   initial begin
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

      // vector table, checked by the monitor
      @(posedge clk); #1;
      out_ready = 1'b1;
      for (int i = 0; i < 8; i++)
         send(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:0]);
      drain();
      check(rd_p == wr_p, "R8 table all delivered", int'(rd_p), int'(wr_p));

      // R10: data wiggling with in_valid low gives nothing
      in_y = 8'd7; in_u = 8'd9; in_v = 8'd250;
      n = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (out_valid) n++;
         @(posedge clk); #1;
         in_y = in_y + 8'd13;
      end
      check(n == 0, "R10 no output while idle", n, 0);

      // R7: latency of one pixel into an empty pipe
      send(8'd10, 8'd128, 8'd128, ref_pix(8'd10, 8'd128, 8'd128));
      n = 0;
      do begin @(negedge clk); n++; end while (!out_valid && n < 10);
      check(n == 3, "R7 latency in negedges after accept", n, 3);
      drain();

      // R7: back-to-back throughput
      t0 = $realtime;
      for (int i = 0; i < 12; i++)
         send(8'(i * 20), 8'(i * 21), 8'(255 - i * 19),
              ref_pix(8'(i * 20), 8'(i * 21), 8'(255 - i * 19)));
      check(($realtime - t0) == 60.0, "R7 twelve pixels in twelve cycles",
            int'($realtime - t0), 60);
      drain();

      // R8: stall holds the output and back-pressures the input
      out_ready = 1'b0;
      fork
         begin
            for (int i = 0; i < 4; i++)
               send(8'(60 + i), 8'(40 + 50 * i), 8'(200 - 30 * i),
                    ref_pix(8'(60 + i), 8'(40 + 50 * i), 8'(200 - 30 * i)));
         end
         begin
            repeat (5) @(negedge clk);
            held = {out_r, out_g, out_b};
            check(out_valid == 1'b1, "R8 out_valid while stalled", int'(out_valid), 1);
            check(in_ready == 1'b0, "R8 in_ready low when full", int'(in_ready), 0);
            repeat (3) @(negedge clk);
            check({out_r, out_g, out_b} == held, "R8 output held during stall",
                  int'({out_r, out_g, out_b}), int'(held));
            @(posedge clk); #1;
            out_ready = 1'b1;
         end
      join
      drain();
      check(rd_p == wr_p, "R8 no drop or duplicate after stall", int'(rd_p), int'(wr_p));

      // random pixels against the reference, with a flickering consumer
      fork
         begin
            for (int i = 0; i < 40; i++) begin
               seed_a = lfsr_next(seed_a);
               send(seed_a[7:0], seed_a[15:8], seed_a[23:16],
                    ref_pix(seed_a[7:0], seed_a[15:8], seed_a[23:16]));
            end
         end
         begin
            for (int i = 0; i < 70; i++) begin
               @(posedge clk); #1;
               seed_b = lfsr_next(seed_b);
               out_ready = seed_b[3] | seed_b[9];
            end
            out_ready = 1'b1;
         end
      join
      drain();
      check(rd_p == wr_p, "R8 random stream fully delivered", int'(rd_p), int'(wr_p));

      // R9: reset with pixels in flight discards them
      out_ready = 1'b0;
      send(8'd1, 8'd2, 8'd3, ref_pix(8'd1, 8'd2, 8'd3));
      send(8'd4, 8'd5, 8'd6, ref_pix(8'd4, 8'd5, 8'd6));
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid cleared by reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9 in_ready after mid-run reset", int'(in_ready), 1);
      @(posedge clk); #1;
      rst = 1'b0;
      out_ready = 1'b1;
      n = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (out_valid) n++;
      end
      check(n == 0, "R9 stale pixels not delivered", n, 0);
      @(posedge clk); #1;
      send(VEC[1][47:40], VEC[1][39:32], VEC[1][31:24], VEC[1][23:0]);
      drain();
      check(rd_p == wr_p, "R9 pipe usable after reset", int'(rd_p), int'(wr_p));

      $display("[TB] %0d tests run, %0d failed",
               n_checks + mon_checks, n_fails + mon_fails);
      $finish;
   end

endmodule